// File: doc/BRIEF.md
# USB Root Hub Port Status Register

This block holds the status and control state of one downstream port of a USB host controller's root hub. Software reads a 32-bit status word and writes a 32-bit command word. A write is a set of one-shot commands, and a 0 in any position does nothing. Because of this, some bit positions mean one thing on read and another on write. For example, bit 9 reads back the low-speed indicator, but writing 1 to it removes port power.

The port hardware feeds the block with several inputs: attach and detach pulses, the speed of the attached device, an overcurrent pulse, and global power commands. It also supplies a power-switching mode and a per-port mask. These decide whether this port's power follows the global commands or its own commands. The block applies the rules that protect a port that is disconnected or unpowered:

- Commands that need a device, sent to an empty port, only raise the connect-change flag.
- Loss of power clears the connection, enable, suspend and reset state.

Port reset signaling is timed by an internal counter. When the reset finishes, the block raises a reset-change flag.

Top module: `usbp_port_status`

## Requirements
- R1: After reset, with power switching supported, the status word reads 0. Bits 5-7, 10-15 and 21-31 always read 0. Writing 0s, or 1s only to those reserved bits, changes nothing.
- R2: Connect-change (bit 16) is set when an attach arrives on a powered, unconnected port, or when a detach arrives on a connected port. Writing 1 to bit 16 clears it.
- R3: Writing 1 to set-reset (bit 4), set-enable (bit 1) or set-suspend (bit 2) while connect status (bit 0) is 0 changes nothing except setting bit 16.
- R4: Writing 1 to bit 4 on a connected port makes reset status (bit 4) read 1 for exactly RST_CYCLES cycles. After that, reset-change (bit 20) reads 1. A set-reset written while reset is active is ignored. Writing 1 to bit 20 clears it.
- R5: Bit 9 reads the low-speed input (1 = low speed) only while bit 0 is 1, and reads 0 otherwise.
- R6: Writing 1 to bit 8 sets power status (bit 8), and writing 1 to bit 9 clears it. In global mode (mode input 0), only the global set and clear inputs change power, and the write commands are ignored.
- R7: In per-port mode (mode input 1) with mask 1, only the bit 8 and bit 9 write commands act. With mask 0, only the global inputs act.
- R8: When power turns off, bits 0, 1, 2 and 4 become 0. An overcurrent pulse turns power off. An attach on an unpowered port is ignored.
- R9: A detach while reset is active drops bit 4 without setting bit 20, and sets bit 16.
- R10: While the device-removable input is 1, an attach sets bit 0 but not bit 16. A root-hub reset pulse then sets bit 16 if the port is connected.
- R11: With PWR_SW = 0, power status always reads 1, and the global, write and overcurrent power events are ignored.
- R12: Writing 1 to bit 1 sets enable (bit 1) and writing 1 to bit 0 clears it. Writing 1 to bit 2 sets suspend (bit 2) and writing 1 to bit 3 clears it. Both set commands need the port to be connected. A detach clears bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 32 | Command word, 1 = perform command |
| rd_data_o | output | 32 | Status word |
| attach_i | input | 1 | Device attach event pulse |
| detach_i | input | 1 | Device detach event pulse |
| low_speed_i | input | 1 | Attached device is low speed |
| ovc_i | input | 1 | Overcurrent event pulse |
| glb_pwr_set_i | input | 1 | Global power-on command pulse |
| glb_pwr_clr_i | input | 1 | Global power-off command pulse |
| pwr_mode_i | input | 1 | 0 = global switching, 1 = per-port switching |
| pwr_mask_i | input | 1 | This port's per-port power mask |
| removable_i | input | 1 | Device-removable setting for this port |
| hub_reset_i | input | 1 | Root-hub reset event pulse |
| port_reset_o | output | 1 | Port reset signaling active |

## Verification
The bench builds two copies of the block. The main copy has power switching enabled and RST_CYCLES = 5, which keeps the exact length of reset signaling, a re-issued reset, and the aborts by detach and by power loss inside a few cycles. A second copy with PWR_SW = 0 shares the same stimulus and is checked after a shared reset. On that copy, power must stay on through global, write and overcurrent events, and an attach must still be accepted.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  // LSB-0 positions; software decodes these
  localparam int B_CCS = 0;
  localparam int B_PES = 1;
  localparam int B_PSS = 2;
  localparam int B_PSC = 3;
  localparam int B_PRS = 4;
  localparam int B_PPS = 8;
  localparam int B_LSD = 9;
  localparam int B_CSC = 16;
  localparam int B_PRC = 20;

  localparam logic [31:0] RSVD_MASK = 32'hFFE0_FCE0;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
    logic clr_csc;
    logic clr_prc;
  } cmd_t;
endpackage

// File: rtl/usbp_cmd_dec.sv
module usbp_cmd_dec
  import usbp_pkg::*;
(
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output cmd_t        cmd_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^(wr_data_i & RSVD_MASK);

  always_comb begin
    cmd_o          = '0;
    cmd_o.clr_en   = wr_en_i & wr_data_i[B_CCS];
    cmd_o.set_en   = wr_en_i & wr_data_i[B_PES];
    cmd_o.set_susp = wr_en_i & wr_data_i[B_PSS];
    cmd_o.clr_susp = wr_en_i & wr_data_i[B_PSC];
    cmd_o.set_rst  = wr_en_i & wr_data_i[B_PRS];
    cmd_o.set_pwr  = wr_en_i & wr_data_i[B_PPS];
    cmd_o.clr_pwr  = wr_en_i & wr_data_i[B_LSD];
    cmd_o.clr_csc  = wr_en_i & wr_data_i[B_CSC];
    cmd_o.clr_prc  = wr_en_i & wr_data_i[B_PRC];
  end
endmodule

// File: rtl/usbp_pwr_ctl.sv
module usbp_pwr_ctl #(
  parameter bit PWR_SW = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_set_i,
  input  logic port_clr_i,
  input  logic glb_set_i,
  input  logic glb_clr_i,
  input  logic mode_i,
  input  logic mask_i,
  input  logic ovc_i,
  output logic pps_o,
  output logic pps_nxt_o
);
  if (PWR_SW) begin : g_sw
    logic pps_q, pps_d, port_sel, do_set, do_clr;

    assign port_sel = mode_i & mask_i;
    assign do_set   = port_sel ? port_set_i : glb_set_i;
    assign do_clr   = port_sel ? port_clr_i : glb_clr_i;

    always_comb begin
      pps_d = pps_q;
      if (ovc_i || do_clr) pps_d = 1'b0;
      else if (do_set)     pps_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pps_q <= 1'b0;
      else         pps_q <= pps_d;
    end

    assign pps_o     = pps_q;
    assign pps_nxt_o = pps_d;

    p_ovc_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovc_i |=> !pps_o);
    p_mask_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i && mask_i && !ovc_i && !port_set_i && !port_clr_i) |=> $stable(pps_o));
    p_glb_route_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i && !ovc_i && !glb_set_i && !glb_clr_i) |=> $stable(pps_o));
  end else begin : g_fixed
    logic unused_pwr;
    assign unused_pwr = ^{clk_i, rst_ni, port_set_i, port_clr_i, glb_set_i,
                          glb_clr_i, mode_i, mask_i, ovc_i};
    assign pps_o     = 1'b1;
    assign pps_nxt_o = 1'b1;
  end
endmodule

// File: rtl/usbp_rst_tmr.sv
module usbp_rst_tmr #(
  parameter int RST_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic clr_chg_i,
  output logic prs_o,
  output logic prsc_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prs_q, prsc_q, done;

  assign done = prs_q && (cnt_q == '0) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prs_q  <= 1'b0;
      prsc_q <= 1'b0;
    end else begin
      if (abort_i) begin
        prs_q <= 1'b0;
        cnt_q <= '0;
      end else if (prs_q) begin
        if (done) prs_q <= 1'b0;
        else      cnt_q <= cnt_q - 1'b1;
      end else if (start_i) begin
        prs_q <= 1'b1;
        cnt_q <= LOAD;
      end

      if (done)           prsc_q <= 1'b1;
      else if (clr_chg_i) prsc_q <= 1'b0;
    end
  end

  assign prs_o  = prs_q;
  assign prsc_o = prsc_q;

  p_start_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prs_o) |-> $past(start_i));
  p_abort_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && prs_o) |=> (!prs_o && !$rose(prsc_o)));
  p_chg_after_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prsc_o) |-> $fell(prs_o));
endmodule

// File: rtl/usbp_port_status.sv
module usbp_port_status
  import usbp_pkg::*;
#(
  parameter bit PWR_SW     = 1'b1,
  parameter int RST_CYCLES = 50000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        attach_i,
  input  logic        detach_i,
  input  logic        low_speed_i,
  input  logic        ovc_i,
  input  logic        glb_pwr_set_i,
  input  logic        glb_pwr_clr_i,
  input  logic        pwr_mode_i,
  input  logic        pwr_mask_i,
  input  logic        removable_i,
  input  logic        hub_reset_i,
  output logic        port_reset_o
);
  cmd_t cmd;
  logic pps, pps_nxt, prs, prsc;
  logic ccs_q, pes_q, pss_q, csc_q;
  logic need_conn, csc_set, drop;

  usbp_cmd_dec u_dec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd)
  );

  usbp_pwr_ctl #(.PWR_SW(PWR_SW)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_set_i (cmd.set_pwr),
    .port_clr_i (cmd.clr_pwr),
    .glb_set_i  (glb_pwr_set_i),
    .glb_clr_i  (glb_pwr_clr_i),
    .mode_i     (pwr_mode_i),
    .mask_i     (pwr_mask_i),
    .ovc_i      (ovc_i),
    .pps_o      (pps),
    .pps_nxt_o  (pps_nxt)
  );

  // power loss or unplug tears down port state
  assign drop = !pps_nxt || detach_i;

  usbp_rst_tmr #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cmd.set_rst && ccs_q),
    .abort_i   (drop),
    .clr_chg_i (cmd.clr_prc),
    .prs_o     (prs),
    .prsc_o    (prsc)
  );

  assign need_conn = cmd.set_rst || cmd.set_en || cmd.set_susp;
  assign csc_set   = (detach_i && ccs_q)
                  || (attach_i && pps && !ccs_q && !removable_i)
                  || (hub_reset_i && removable_i && ccs_q)
                  || (need_conn && !ccs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q <= 1'b0;
      pes_q <= 1'b0;
      pss_q <= 1'b0;
      csc_q <= 1'b0;
    end else begin
      if (drop)                  ccs_q <= 1'b0;
      else if (attach_i && pps)  ccs_q <= 1'b1;

      if (drop)                          pes_q <= 1'b0;
      else if (cmd.clr_en)               pes_q <= 1'b0;
      else if (cmd.set_en && ccs_q)      pes_q <= 1'b1;

      if (drop)                          pss_q <= 1'b0;
      else if (cmd.clr_susp)             pss_q <= 1'b0;
      else if (cmd.set_susp && ccs_q)    pss_q <= 1'b1;

      if (csc_set)          csc_q <= 1'b1;
      else if (cmd.clr_csc) csc_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o        = '0;
    rd_data_o[B_CCS] = ccs_q;
    rd_data_o[B_PES] = pes_q;
    rd_data_o[B_PSS] = pss_q;
    rd_data_o[B_PRS] = prs;
    rd_data_o[B_PPS] = pps;
    rd_data_o[B_LSD] = ccs_q & low_speed_i;
    rd_data_o[B_CSC] = csc_q;
    rd_data_o[B_PRC] = prsc;
  end

  assign port_reset_o = prs;

  p_off_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pps |-> (!ccs_q && !pes_q && !pss_q && !prs));
  p_detach_csc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detach_i && ccs_q) |=> csc_q);
  p_empty_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_conn && !ccs_q) |=> (csc_q && !prs && $stable(pes_q) && $stable(pss_q)));
  p_lsd_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[B_CCS] |-> !rd_data_o[B_LSD]);
  p_en_needs_conn_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pes_q) |-> $past(ccs_q));
endmodule

// File: tb/sim_usbp_port_status.sv
module sim_usbp_port_status;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic att = 0, det = 0, ls = 0, ovc = 0, gset = 0, gclr = 0;
  logic psm = 0, msk = 0, rmv = 0, hrst = 0;
  logic [31:0] rd0, rd1;
  logic prt0, prt1;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  usbp_port_status #(.PWR_SW(1'b1), .RST_CYCLES(5)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd0), .attach_i(att), .detach_i(det), .low_speed_i(ls),
    .ovc_i(ovc), .glb_pwr_set_i(gset), .glb_pwr_clr_i(gclr),
    .pwr_mode_i(psm), .pwr_mask_i(msk), .removable_i(rmv),
    .hub_reset_i(hrst), .port_reset_o(prt0));

  usbp_port_status #(.PWR_SW(1'b0), .RST_CYCLES(5)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd1), .attach_i(att), .detach_i(det), .low_speed_i(ls),
    .ovc_i(ovc), .glb_pwr_set_i(gset), .glb_pwr_clr_i(gclr),
    .pwr_mode_i(psm), .pwr_mask_i(msk), .removable_i(rmv),
    .hub_reset_i(hrst), .port_reset_o(prt1));

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        a, d, o, gs, gc, pm, mk, l;
    logic [3:0]  req;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 32'h0,         0,0,0,1,0,0,0,0, 4'd6,  32'h0000_0100}, // R6 global on
    '{1'b0, 32'h0,         1,0,0,0,0,0,0,0, 4'd2,  32'h0001_0101}, // R2 attach
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,0, 4'd2,  32'h0000_0101}, // R2 clear
    '{1'b1, 32'h0,         0,0,0,0,0,0,0,0, 4'd1,  32'h0000_0101}, // R1 zero write
    '{1'b0, 32'h0,         0,0,0,0,1,1,1,0, 4'd7,  32'h0000_0101}, // R7 global masked
    '{1'b1, 32'h0000_0200, 0,0,0,0,0,1,1,0, 4'd8,  32'h0000_0000}, // R7/R8 port off
    '{1'b0, 32'h0,         1,0,0,0,0,1,1,0, 4'd8,  32'h0000_0000}, // R8 attach unpowered
    '{1'b0, 32'h0,         0,0,0,1,0,1,1,0, 4'd7,  32'h0000_0000}, // R7 global set masked
    '{1'b1, 32'h0000_0100, 0,0,0,0,0,1,1,0, 4'd7,  32'h0000_0100}, // R7 port set
    '{1'b1, 32'h0000_0200, 0,0,0,0,0,0,0,0, 4'd6,  32'h0000_0100}, // R6 port cmd ignored
    '{1'b1, 32'h0000_0200, 0,0,0,0,0,1,0,0, 4'd7,  32'h0000_0100}, // R7 mask 0
    '{1'b0, 32'h0,         0,0,0,0,1,1,0,0, 4'd7,  32'h0000_0000}, // R7 global clr
    '{1'b0, 32'h0,         0,0,0,1,0,0,0,0, 4'd6,  32'h0000_0100}, // R6
    '{1'b0, 32'h0,         1,0,0,0,0,0,0,1, 4'd5,  32'h0001_0301}, // R5 low speed
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,1, 4'd2,  32'h0000_0301},
    '{1'b1, 32'h0000_0002, 0,0,0,0,0,0,0,1, 4'd12, 32'h0000_0303}, // R12 enable
    '{1'b1, 32'h0000_0004, 0,0,0,0,0,0,0,1, 4'd12, 32'h0000_0307}, // R12 suspend
    '{1'b1, 32'h0000_0008, 0,0,0,0,0,0,0,1, 4'd12, 32'h0000_0303}, // R12 resume
    '{1'b1, 32'h0000_0001, 0,0,0,0,0,0,0,1, 4'd12, 32'h0000_0301}, // R12 disable
    '{1'b1, 32'h0000_0002, 0,0,0,0,0,0,0,1, 4'd12, 32'h0000_0303},
    '{1'b0, 32'h0,         0,1,0,0,0,0,0,1, 4'd5,  32'h0001_0100}, // R5 R12 detach
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,0, 4'd2,  32'h0000_0100},
    '{1'b1, 32'h0000_0010, 0,0,0,0,0,0,0,0, 4'd3,  32'h0001_0100}, // R3 reset empty
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,0, 4'd2,  32'h0000_0100},
    '{1'b1, 32'h0000_0004, 0,0,0,0,0,0,0,0, 4'd3,  32'h0001_0100}, // R3 suspend empty
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,0, 4'd2,  32'h0000_0100},
    '{1'b1, 32'hFFE0_FCE0, 0,0,0,0,0,0,0,0, 4'd1,  32'h0000_0100}, // R1 reserved
    '{1'b0, 32'h0,         1,0,0,0,0,0,0,0, 4'd2,  32'h0001_0101},
    '{1'b0, 32'h0,         0,0,1,0,0,0,0,0, 4'd8,  32'h0001_0000}, // R8 overcurrent
    '{1'b1, 32'h0001_0000, 0,0,0,0,0,0,0,0, 4'd2,  32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_data = '0; att = 0; det = 0; ovc = 0;
    gset = 0; gclr = 0; hrst = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset u0", rd0, 32'h0);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; wr_data = VEC[i].wd;
      att = VEC[i].a; det = VEC[i].d; ovc = VEC[i].o;
      gset = VEC[i].gs; gclr = VEC[i].gc;
      psm = VEC[i].pm; msk = VEC[i].mk; ls = VEC[i].l;
      tick();
      chk($sformatf("R%0d vec %0d", VEC[i].req, i), rd0, VEC[i].exp);
    end
    psm = 0; msk = 0; ls = 0;

    // R4 reset timing with re-issue
    gset = 1; tick();
    att = 1; tick();
    wr(32'h0001_0000);
    wr(32'h0000_0010);
    chk("R4 reset start", rd0, 32'h0000_0111);
    chk("R4 reset pin", {31'b0, prt0}, 32'h1);
    tick();
    wr(32'h0000_0010);
    tick();
    tick();
    chk("R4 reset still active", rd0, 32'h0000_0111);
    tick();
    chk("R4 reset done", rd0, 32'h0010_0101);
    wr(32'h0010_0000);
    chk("R4 change cleared", rd0, 32'h0000_0101);

    // R9 detach during reset
    wr(32'h0000_0010);
    det = 1; tick();
    chk("R9 detach in reset", rd0, 32'h0001_0100);
    wr(32'h0001_0000);

    // R8 power loss during reset
    att = 1; tick();
    wr(32'h0001_0000);
    wr(32'h0000_0010);
    gclr = 1; tick();
    chk("R8 power off in reset", rd0, 32'h0);
    repeat (6) tick();
    chk("R8 no late reset change", rd0, 32'h0);

    // R10 removable device
    rmv = 1;
    gset = 1; tick();
    att = 1; tick();
    chk("R10 attach silent", rd0, 32'h0000_0101);
    hrst = 1; tick();
    chk("R10 hub reset report", rd0, 32'h0001_0101);
    rmv = 0;

    // R11 fixed power copy
    rst_ni = 0;
    @(negedge clk);
    chk("R1 reset again u0", rd0, 32'h0);
    chk("R11 reset u1", rd1, 32'h0000_0100);
    rst_ni = 1;
    @(negedge clk);
    gclr = 1; tick();
    wr(32'h0000_0200);
    ovc = 1; tick();
    chk("R11 power held", rd1, 32'h0000_0100);
    att = 1; tick();
    chk("R11 attach accepted", rd1, 32'h0001_0101);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule